// File: doc/BRIEF.md
# Flash Status Register and Write-Protection Gate

This block holds the status byte of a serial NOR flash. It decides whether each command that would modify the device is allowed to run. An upstream decoder hands it single-cycle command strobes: set latch, clear latch, status write with a data byte, page program, sector erase and whole-array erase. A shared target address comes with the strobes, and the active-low protect pin is sampled on every clock.

The gate combines four things: a write-enable latch, a status-write lock bit, a three-bit protection level and the pin. A status write needs the latch to be set. The write is refused whenever the lock bit is set while the pin is low; this is the hardware-locked state. That state is reached in either order of events and ends only when the pin returns high. Program and erase commands are filtered against a top-of-array region that the protection level selects, counted in 64 KB sectors.

For each modifying command the block answers with a one-cycle accept or reject pulse one clock after the strobe. The status byte changes on the same edge. The array itself and the program/erase timing belong to the downstream sequencer.

Top module: `flash_wp_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `status` reads 0x00.
- R2: A `cmd_wren` strobe sets status bit 1 (the latch). A `cmd_wrdi` strobe clears it.
- R3: With status bit 7 at 0, a status write is accepted exactly when the latch is set, whatever the pin level. An accepted write copies data bits 7 and 4:2 into status bits 7 and 4:2. Status bits 6:5 and 0 always read 0.
- R4: With status bit 7 at 1 and `wp_n` high, a status write is accepted exactly when the latch is set.
- R5: With status bit 7 at 1 and `wp_n` low, every status write is rejected and bits 7 and 4:2 keep their value. This holds whether the pin fell before or after bit 7 was set, and it is released by raising `wp_n`.
- R6: The protection level L in status bits 4:2 guards the sectors whose index `cmd_addr[20:16]` is at least 32 minus N. N is 0 for L=0, 2^(L-1) for L=1..5, and 32 for L=6 or 7.
- R7: Page program and sector erase are accepted exactly when the latch is set and the target sector lies outside the guarded region.
- R8: Whole-array erase is accepted exactly when the latch is set and L is 0.
- R9: Every accepted status write, program or erase clears the latch. A rejected command leaves the whole status byte unchanged.
- R10: Each modifying strobe gives exactly one pulse, on `cmd_acc` or `cmd_rej`, one clock after the strobe, at vector index 0 status write, 1 program, 2 sector erase, 3 whole-array erase. The status byte updates on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wp_n | input | 1 | Active-low write-protect pin level |
| cmd_wren | input | 1 | Set-latch strobe |
| cmd_wrdi | input | 1 | Clear-latch strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| wrsr_data | input | 8 | Data byte of the status write |
| cmd_pp | input | 1 | Page program strobe |
| cmd_se | input | 1 | Sector erase strobe |
| cmd_be | input | 1 | Whole-array erase strobe |
| cmd_addr | input | 21 | Byte address of program or sector erase |
| status | output | 8 | Status byte: 7 lock, 4:2 level, 1 latch |
| cmd_acc | output | 4 | Accept pulses, one bit per modifying command |
| cmd_rej | output | 4 | Reject pulses, one bit per modifying command |

## Verification
The assertions assume that the decoder raises at most one command strobe per cycle and holds each strobe for a single clock. The one-pulse-per-strobe property depends on that. The stimulus drives every command through a task that sets one strobe for one cycle, and the random phase draws a single command per cycle. The pin level is changed only between commands, at the same edge-safe instant as the strobes, so each decision sees one stable pin value.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  localparam int unsigned LVL_W = 3;

  typedef struct packed {
    logic             lock;
    logic [1:0]       zero;
    logic [LVL_W-1:0] lvl;
    logic             wel;
    logic             busy;
  } fwp_status_t;

  localparam int unsigned OP_SR = 0;
  localparam int unsigned OP_PP = 1;
  localparam int unsigned OP_SE = 2;
  localparam int unsigned OP_BE = 3;
  localparam int unsigned OP_N  = 4;

endpackage

// File: rtl/fwp_region.sv
module fwp_region
  import flash_wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned SECT_W = 5
) (
  input  logic [LVL_W-1:0]  lvl,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              lvl_zero
);

  localparam int unsigned CNT_W = SECT_W + 1;
  localparam logic [CNT_W-1:0] NUM_SECT = CNT_W'(1) << SECT_W;

  logic [SECT_W-1:0] sector;
  logic [CNT_W-1:0]  guard_cnt;
  logic [CNT_W-1:0]  low_bound;

  assign sector = addr[ADDR_W-1 -: SECT_W];

  always_comb begin
    if (lvl == '0) begin
      guard_cnt = '0;
    end else if ((int'(lvl) - 1) >= int'(SECT_W)) begin
      guard_cnt = NUM_SECT;
    end else begin
      guard_cnt = CNT_W'(1) << (lvl - LVL_W'(1));
    end
  end

  assign low_bound = NUM_SECT - guard_cnt;
  assign hit       = (guard_cnt != '0) && ({1'b0, sector} >= low_bound);
  assign lvl_zero  = (lvl == '0);

  always_comb begin
    if (lvl_zero) begin
      AST_NO_GUARD_AT_ZERO: assert (!hit); // R6
    end
  end

endmodule

// File: rtl/fwp_status_reg.sv
module fwp_status_reg
  import flash_wp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_wel,
  input  logic             clr_wel,
  input  logic             load_en,
  input  logic             load_lock,
  input  logic [LVL_W-1:0] load_lvl,
  input  logic             wp_n,
  output fwp_status_t      sr_q
);

  fwp_status_t sr_d;
  logic        upd_en;

  always_comb begin
    sr_d      = sr_q;
    sr_d.zero = '0;
    sr_d.busy = 1'b0;
    if (load_en) begin
      sr_d.lock = load_lock;
      sr_d.lvl  = load_lvl;
    end
    if (set_wel) sr_d.wel = 1'b1;
    if (clr_wel) sr_d.wel = 1'b0;
  end

  assign upd_en = load_en | set_wel | clr_wel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (upd_en) begin
      sr_q <= sr_d;
    end
  end

  AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q.lock && !wp_n) |=> $stable({sr_q.lock, sr_q.lvl})); // R5

  AST_FILL_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q.zero == 2'b00) && !sr_q.busy); // R3

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned SECT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic              cmd_pp,
  input  logic              cmd_se,
  input  logic              cmd_be,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        status,
  output logic [OP_N-1:0]   cmd_acc,
  output logic [OP_N-1:0]   cmd_rej
);

  fwp_status_t      sr_q;
  fwp_status_t      wr_img;
  logic             hw_lock;
  logic             region_hit;
  logic             lvl_zero;
  logic [OP_N-1:0]  strobe;
  logic [OP_N-1:0]  go;
  logic [OP_N-1:0]  acc_q;
  logic [OP_N-1:0]  rej_q;

  fwp_region #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_region (
    .lvl      (sr_q.lvl),
    .addr     (cmd_addr),
    .hit      (region_hit),
    .lvl_zero (lvl_zero)
  );

  assign wr_img  = fwp_status_t'(wrsr_data);
  assign hw_lock = sr_q.lock & ~wp_n;

  assign strobe[OP_SR] = cmd_wrsr;
  assign strobe[OP_PP] = cmd_pp;
  assign strobe[OP_SE] = cmd_se;
  assign strobe[OP_BE] = cmd_be;

  assign go[OP_SR] = cmd_wrsr & sr_q.wel & ~hw_lock;
  assign go[OP_PP] = cmd_pp   & sr_q.wel & ~region_hit;
  assign go[OP_SE] = cmd_se   & sr_q.wel & ~region_hit;
  assign go[OP_BE] = cmd_be   & sr_q.wel & lvl_zero;

  fwp_status_reg u_sr (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_wel   (cmd_wren),
    .clr_wel   (cmd_wrdi | (|go)),
    .load_en   (go[OP_SR]),
    .load_lock (wr_img.lock),
    .load_lvl  (wr_img.lvl),
    .wp_n      (wp_n),
    .sr_q      (sr_q)
  );

  for (genvar g = 0; g < OP_N; g++) begin : g_pulse
    logic acc_d;
    logic rej_d;
    assign acc_d = go[g];
    assign rej_d = strobe[g] & ~go[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[g] <= 1'b0;
        rej_q[g] <= 1'b0;
      end else begin
        acc_q[g] <= acc_d;
        rej_q[g] <= rej_d;
      end
    end
  end

  assign status  = sr_q;
  assign cmd_acc = acc_q;
  assign cmd_rej = rej_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be})); // R10

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmd_acc, cmd_rej}) <= 1); // R10

  AST_SR_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wrsr |=> (cmd_acc[OP_SR] == ($past(sr_q.wel) && !$past(hw_lock)))); // R4

  AST_PROG_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pp || cmd_se) && region_hit |=> !cmd_acc[OP_PP] && !cmd_acc[OP_SE]); // R7

  AST_BULK_LVL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_be && !lvl_zero |=> cmd_rej[OP_BE]); // R8

  AST_ACC_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_acc) |-> !status[1]); // R9

endmodule

// File: tb/flash_wp_ctrl_bench.sv
module flash_wp_ctrl_bench;

  localparam int ADDR_W = 21;

  logic              clk;
  logic              rst_n;
  logic              wp_n;
  logic              cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be;
  logic [7:0]        wrsr_data;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        status;
  logic [3:0]        cmd_acc, cmd_rej;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit live   = 0;

  int e_lock = 0, e_lvl = 0, e_wel = 0;
  logic [3:0] e_acc = '0, e_rej = '0;

  flash_wp_ctrl u_flash_wp_ctrl (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .wrsr_data(wrsr_data), .cmd_pp(cmd_pp), .cmd_se(cmd_se), .cmd_be(cmd_be),
    .cmd_addr(cmd_addr), .status(status), .cmd_acc(cmd_acc), .cmd_rej(cmd_rej)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int guarded(input int lvl);
    case (lvl)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      3:       return 4;
      4:       return 8;
      5:       return 16;
      default: return 32;
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return {e_lock[0], 2'b00, e_lvl[2:0], e_wel[0], 1'b0};
  endfunction

  // Behavioural reference, evaluated on every rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_lock = 0; e_lvl = 0; e_wel = 0; e_acc = '0; e_rej = '0;
    end else begin
      int sect;
      bit ok;
      sect  = int'(cmd_addr[20:16]);
      e_acc = '0;
      e_rej = '0;
      if (cmd_wren) e_wel = 1;
      if (cmd_wrdi) e_wel = 0;
      if (cmd_wrsr) begin
        ok = (e_wel == 1) && !(e_lock == 1 && wp_n == 1'b0);
        if (ok) begin
          e_lock = int'(wrsr_data[7]);
          e_lvl  = int'(wrsr_data[4:2]);
          e_wel  = 0;
          e_acc[0] = 1'b1;
        end else e_rej[0] = 1'b1;
      end
      if (cmd_pp || cmd_se) begin
        ok = (e_wel == 1) && (sect < 32 - guarded(e_lvl));
        if (ok) e_wel = 0;
        if (cmd_pp) begin e_acc[1] = ok; e_rej[1] = !ok; end
        else        begin e_acc[2] = ok; e_rej[2] = !ok; end
      end
      if (cmd_be) begin
        ok = (e_wel == 1) && (e_lvl == 0);
        if (ok) e_wel = 0;
        e_acc[3] = ok; e_rej[3] = !ok;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference, away from the rising edge.
  always @(negedge clk) begin
    if (live && rst_n) begin
      check("R3 status", int'(status), int'(exp_status()));
      check("R4 sr pulse", int'({cmd_acc[0], cmd_rej[0]}), int'({e_acc[0], e_rej[0]}));
      check("R7 pp/se pulse", int'({cmd_acc[2:1], cmd_rej[2:1]}), int'({e_acc[2:1], e_rej[2:1]}));
      check("R8 be pulse", int'({cmd_acc[3], cmd_rej[3]}), int'({e_acc[3], e_rej[3]}));
    end
  end

  task automatic issue(input int kind, input logic [7:0] d, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    wrsr_data = d;
    cmd_addr  = a;
    cmd_wren  = (kind == 1);
    cmd_wrdi  = (kind == 2);
    cmd_wrsr  = (kind == 3);
    cmd_pp    = (kind == 4);
    cmd_se    = (kind == 5);
    cmd_be    = (kind == 6);
    @(negedge clk);
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be} = '0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk);
    wp_n = v;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wp_n = 1'b1; wrsr_data = '0; cmd_addr = '0;
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be} = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", int'(status), 0);
    rst_n = 1'b1;
    live  = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(status), 0);

    issue(1, 8'h00, '0);
    check("R2 wren", int'(status), 8'h02);
    issue(2, 8'h00, '0);
    check("R2 wrdi", int'(status), 8'h00);

    issue(3, 8'hFF, '0);
    check("R9 rejected sr write", int'({cmd_rej[0], status}), 9'h100);

    set_pin(1'b0);
    issue(1, 8'h00, '0);
    issue(3, 8'hFF, '0);
    check("R3 accepted pin low", int'({cmd_acc[0], status}), 9'h19C);
    check("R10 pulse one cycle later", int'(cmd_rej), 0);
    @(negedge clk);
    check("R10 pulse ends", int'({cmd_acc, cmd_rej}), 0);

    issue(1, 8'h00, '0);
    issue(3, 8'h00, '0);
    check("R5 locked reject", int'({cmd_rej[0], status}), 9'h19E);
    set_pin(1'b1);
    issue(3, 8'h00, '0);
    check("R5 released by pin", int'({cmd_acc[0], status}), 9'h100);

    issue(1, 8'h00, '0);
    issue(3, 8'h80, '0);
    set_pin(1'b0);
    issue(1, 8'h00, '0);
    issue(3, 8'h00, '0);
    check("R5 pin after bit", int'({cmd_rej[0], status}), 9'h182);
    set_pin(1'b1);
    issue(3, 8'h00, '0);
    check("R4 pin high accepts", int'({cmd_acc[0], status}), 9'h100);

    for (int lvl = 0; lvl < 8; lvl++) begin
      issue(1, 8'h00, '0);
      issue(3, 8'(lvl << 2), '0);
      for (int s = 0; s < 32; s++) begin
        issue(1, 8'h00, '0);
        issue(4, 8'h00, {5'(s), 16'h1234});
        check("R6 region", int'(cmd_acc[1]), int'(s < 32 - guarded(lvl)));
        issue(1, 8'h00, '0);
        issue(5, 8'h00, {5'(s), 16'h0000});
      end
      issue(1, 8'h00, '0);
      issue(6, 8'h00, '0);
      check("R8 bulk", int'(cmd_acc[3]), int'(lvl == 0));
      issue(4, 8'h00, '0);
    end

    for (int i = 0; i < 4000; i++) begin
      int k;
      k = int'($urandom_range(0, 7));
      if (k == 7) set_pin(~wp_n);
      else issue(k, 8'($urandom), ADDR_W'($urandom));
    end

    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule